// File: doc/BRIEF.md
# Paged memory address mapper

This block extends the reach of an 8-bit processor whose address bus is 16 bits wide. A file of sixteen 12-bit page registers sits beside the processor. The four most significant address bits pick one register, and that register's contents leave the block as a 12-bit physical page number. Software sets up the page table by writing the registers, and can read it back, through a chip-select and read/write access port. Writes need an extra strobe.

A mode input turns the translation on or off. In map mode the selected register drives the page output. In pass mode the raw upper address bits appear on the top four page lines and all lower page lines are zero, so the processor sees an untranslated layout. The access port picks its register through a select input of its own. A register can therefore be set up while a different one is translating.

Top module: `page_mapper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all sixteen registers are cleared to zero. After reset every register reads back as 0x000.
- R2: When `pass_sel` is 0 (map mode), `page_out` equals the register whose index is `addr_hi`. The output follows `addr_hi` combinationally.
- R3: When `pass_sel` is 1 (pass mode), `page_out[11:8]` equals `addr_hi` and `page_out[7:0]` is 0, whatever the registers hold.
- R4: When `cs_n` is 0 and `rd_wr_n` is 1, `rd_valid` is 1 and `rd_data` holds the register whose index is `reg_sel`.
- R5: In every other combination of `cs_n` and `rd_wr_n`, `rd_valid` is 0 and `rd_data` is 0x000.
- R6: A register is written only at a rising edge where `cs_n`, `rd_wr_n` and `wstrb_n` are all 0. The write stores `wr_data` into the register indexed by `reg_sel`. If any of the three is 1, no register changes.
- R7: A written value is visible on `page_out` and on `rd_data` from the cycle after the write edge. Before that edge the old value is still shown.
- R8: The register reached through `reg_sel` is independent of `addr_hi`. Writing one register leaves the translation of every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_hi | input | 4 | Processor address bits 15..12 |
| pass_sel | input | 1 | 0 = map mode, 1 = pass mode |
| reg_sel | input | 4 | Register index for the access port |
| cs_n | input | 1 | Chip select, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| wstrb_n | input | 1 | Write strobe, active low |
| wr_data | input | 12 | Data to be written |
| rd_data | output | 12 | Read-back data, zero when not reading |
| rd_valid | output | 1 | High while a read is active |
| page_out | output | 12 | Physical page number |

## Verification
A write through the access port can target the same register that `addr_hi` is translating in that very cycle. The bench provokes this directly: it sets `reg_sel` equal to `addr_hi` in map mode and raises a write. It checks that `page_out` still shows the old contents before the edge and the new contents after it. Random cycles also mix writes to other indices with translation, and each cycle is judged against a bench model updated only at the edges where all three write conditions hold.

// File: rtl/mmap_pkg.sv
// Shared types for the page mapper.
// Assumes: the access decode is a pair of one-bit qualifiers.
package mmap_pkg;
    typedef struct packed {
        logic rd;   // read qualified
        logic wr;   // write qualified
    } acc_t;
endpackage

// File: rtl/map_access_ctrl.sv
// Decodes the chip-select, read/write and strobe inputs into read and write qualifiers.
// Assumes: all inputs are active low except rd_wr_n, where 1 means read.
module map_access_ctrl
    import mmap_pkg::*;
(
    input  logic cs_n,
    input  logic rd_wr_n,
    input  logic wstrb_n,
    output acc_t acc
);
    // Purpose: form the read and write qualifiers.
    always_comb begin
        acc.rd = !cs_n && rd_wr_n;
        acc.wr = !cs_n && !rd_wr_n && !wstrb_n;
    end
endmodule

// File: rtl/map_regfile.sv
// Page register file with one write port and two read ports (translation and access).
// Assumes: synchronous active-low reset; writes land on the rising edge.
module map_regfile #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 12,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  map_idx,
    output logic [DATA_W-1:0] map_q,
    input  logic [IDX_W-1:0]  acc_idx,
    output logic [DATA_W-1:0] acc_q
);
    logic [DEPTH-1:0][DATA_W-1:0] mem;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Purpose: hold one page register, loaded when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && (waddr == IDX_W'(g)))
                mem[g] <= wdata;
        end
    end

    // Purpose: drive the two read ports.
    always_comb begin
        map_q = mem[map_idx];
        acc_q = mem[acc_idx];
    end

    // R1: reset clears the whole file
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (mem == '0));
    // R6: no write qualifier, no change
    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem));
    // R6: a qualified write stores the data at its index
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/map_out_mux.sv
// Selects between the translated page and the raw upper address bits.
// Assumes: PAGE_W is at least IDX_W; in pass mode the low lines are forced to zero.
module map_out_mux #(
    parameter int IDX_W  = 4,
    parameter int PAGE_W = 12,
    localparam int LOW_W = PAGE_W - IDX_W
) (
    input  logic              pass_sel,
    input  logic [IDX_W-1:0]  addr_hi,
    input  logic [PAGE_W-1:0] mapped,
    output logic [PAGE_W-1:0] page_out
);
    // Purpose: choose the page output source.
    always_comb begin
        if (pass_sel)
            page_out = {addr_hi, {LOW_W{1'b0}}};
        else
            page_out = mapped;
    end
endmodule

// File: rtl/page_mapper.sv
// Top of the paged address mapper: register file, access decode and output selection.
// Assumes: a single clock; the access port and translation share the register file.
module page_mapper #(
    parameter int IDX_W  = 4,
    parameter int PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  addr_hi,
    input  logic              pass_sel,
    input  logic [IDX_W-1:0]  reg_sel,
    input  logic              cs_n,
    input  logic              rd_wr_n,
    input  logic              wstrb_n,
    input  logic [PAGE_W-1:0] wr_data,
    output logic [PAGE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [PAGE_W-1:0] page_out
);
    import mmap_pkg::*;
    localparam int LOW_W = PAGE_W - IDX_W;

    acc_t              acc;
    logic [PAGE_W-1:0] map_q;
    logic [PAGE_W-1:0] acc_q;

    map_access_ctrl u_acc (
        .cs_n    (cs_n),
        .rd_wr_n (rd_wr_n),
        .wstrb_n (wstrb_n),
        .acc     (acc)
    );

    map_regfile #(.IDX_W(IDX_W), .DATA_W(PAGE_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (acc.wr),
        .waddr   (reg_sel),
        .wdata   (wr_data),
        .map_idx (addr_hi),
        .map_q   (map_q),
        .acc_idx (reg_sel),
        .acc_q   (acc_q)
    );

    map_out_mux #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_mux (
        .pass_sel (pass_sel),
        .addr_hi  (addr_hi),
        .mapped   (map_q),
        .page_out (page_out)
    );

    // Purpose: gate the read-back data with the read qualifier.
    always_comb begin
        rd_valid = acc.rd;
        rd_data  = acc.rd ? acc_q : '0;
    end

    // R2: translation and access read agree on the same index
    a_r2_map_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_sel && acc.rd && (reg_sel == addr_hi)) |-> (page_out == rd_data));
    // R3: pass mode keeps the low page lines at zero
    a_r3_pass_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pass_sel |-> (page_out[LOW_W-1:0] == '0));
    // R5: no read, no data
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));
    // R7: a write to the translated index shows on the page output next cycle
    a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.wr && (reg_sel == addr_hi) && !pass_sel) ##1
        ((addr_hi == $past(addr_hi)) && !pass_sel) |-> (page_out == $past(wr_data)));
endmodule

// File: tb/test_page_mapper.sv
// Self-checking bench: directed corner cases plus seeded random cycles against a model.
module test_page_mapper;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  addr_hi;
    logic        pass_sel;
    logic [3:0]  reg_sel;
    logic        cs_n;
    logic        rd_wr_n;
    logic        wstrb_n;
    logic [11:0] wr_data;
    logic [11:0] rd_data;
    logic        rd_valid;
    logic [11:0] page_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [11:0] model [16];

    always #10 clk = ~clk;

    page_mapper i_page_mapper (
        .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .pass_sel(pass_sel),
        .reg_sel(reg_sel), .cs_n(cs_n), .rd_wr_n(rd_wr_n), .wstrb_n(wstrb_n),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .page_out(page_out)
    );

    function automatic logic [11:0] exp_page(input logic ps, input logic [3:0] a);
        return ps ? {a, 8'h00} : model[a];
    endfunction

    function automatic logic [12:0] exp_read(input logic c, input logic rw, input logic [3:0] s);
        return (!c && rw) ? {1'b1, model[s]} : 13'h0;
    endfunction

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check({req, " page"}, {1'b0, page_out}, {1'b0, exp_page(pass_sel, addr_hi)});
        check({req, " read"}, {rd_valid, rd_data}, exp_read(cs_n, rd_wr_n, reg_sel));
    endtask

    // Drive at negedge, settle, check, then let the posedge commit a write into the model.
    task automatic cycle(input string req, input logic [3:0] a, input logic ps, input logic [3:0] s,
                         input logic c, input logic rw, input logic st, input logic [11:0] d);
        @(negedge clk);
        addr_hi = a; pass_sel = ps; reg_sel = s; cs_n = c; rd_wr_n = rw; wstrb_n = st; wr_data = d;
        #2;
        check_outputs(req);
        @(posedge clk);
        if (!c && !rw && !st) model[s] = d;
    endtask

    task automatic readback(input string req, input logic [3:0] s);
        cycle(req, 4'h0, 1'b1, s, 1'b0, 1'b1, 1'b1, 12'h000);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 12'h000;
        rst_n = 1'b0; addr_hi = 0; pass_sel = 0; reg_sel = 0;
        cs_n = 1; rd_wr_n = 1; wstrb_n = 1; wr_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: every register reads zero after reset
        for (int i = 0; i < 16; i++) readback("R1", 4'(i));
        // R2: map mode on a cleared file
        cycle("R2", 4'h9, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 12'h000);
        // R6: write with strobe high is ignored, then with cs high, then a read with strobe low
        cycle("R6", 4'h3, 1'b0, 4'h3, 1'b0, 1'b0, 1'b1, 12'hABC);
        readback("R6", 4'h3);
        cycle("R6", 4'h3, 1'b0, 4'h3, 1'b1, 1'b0, 1'b0, 12'hABC);
        readback("R6", 4'h3);
        cycle("R6", 4'h3, 1'b0, 4'h3, 1'b0, 1'b1, 1'b0, 12'hABC);
        readback("R6", 4'h3);
        // R7: same-cycle write to the translated index, old value before edge, new after
        cycle("R7", 4'h5, 1'b0, 4'h5, 1'b0, 1'b0, 1'b0, 12'h5A5);
        cycle("R7", 4'h5, 1'b0, 4'h5, 1'b1, 1'b1, 1'b1, 12'h000);
        cycle("R7", 4'h5, 1'b0, 4'h5, 1'b0, 1'b1, 1'b1, 12'h000);
        // R8: writing index 6 leaves translation of index 5 alone
        cycle("R8", 4'h5, 1'b0, 4'h6, 1'b0, 1'b0, 1'b0, 12'h123);
        cycle("R8", 4'h5, 1'b0, 4'h6, 1'b1, 1'b1, 1'b1, 12'h000);
        cycle("R8", 4'h6, 1'b0, 4'h6, 1'b0, 1'b1, 1'b1, 12'h000);
        // R3: pass mode hides a loaded register
        cycle("R3", 4'h5, 1'b1, 4'h0, 1'b1, 1'b1, 1'b1, 12'h000);
        cycle("R3", 4'hF, 1'b1, 4'h0, 1'b1, 1'b1, 1'b1, 12'h000);
        // R4 and R5: read qualifiers
        cycle("R4", 4'h0, 1'b1, 4'h5, 1'b0, 1'b1, 1'b0, 12'h000);
        cycle("R5", 4'h0, 1'b1, 4'h5, 1'b1, 1'b1, 1'b1, 12'h000);
        // Random mix across all functions
        void'($urandom(32'd1234));
        for (int n = 0; n < 400; n++) begin
            logic [3:0] ra = 4'($urandom);
            logic [3:0] rs = 4'($urandom);
            logic rps = ($urandom % 4) == 0;
            logic rc  = ($urandom % 4) == 0;
            logic rrw = $urandom % 2;
            logic rst = ($urandom % 3) == 0;
            cycle("R2/R4/R6 random", ra, rps, rs, rc, rrw, rst, 12'($urandom));
        end
        // R6/R8: final sweep of the whole file
        for (int i = 0; i < 16; i++) readback("R8 sweep", 4'(i));
        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 16; i++) model[i] = 12'h000;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) readback("R1 rereset", 4'(i));
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule